// File: doc/BRIEF.md
# Supply Window Qualification Sequencer

This block decides when the gate drive of an external pass transistor may be switched on. A sampled and divided supply voltage arrives as an unsigned code every clock cycle. Two hysteresis comparators turn that code into an undervoltage flag and an overvoltage flag. Each comparator has its own pair of parameterised thresholds. The supply counts as in window while both flags are clear.

A sequencer acts on the window state. After reset, and after every lockout, the supply must stay in window for a power-on delay before the gate request goes high. Once the gate is on, a drop out of the window removes the request only after a filter time. A shorter excursion is ignored. When the supply comes back after a voltage fault, the gate is restored at once, without the power-on delay. A separate lockout input removes the gate request in the same cycle.

The power-on delay and the filter time are equally long. Both are counted in ticks of one prescaled timebase.

Top module: `supply_window_seq`

## Requirements
- R1: While reset is held, and right after it, gate_en=0, uv_flag=1, ov_flag=0 and v_fault=0.
- R2: The undervoltage flag uses hysteresis and updates one clock after the code. It clears when sample_code > 364 (UV_RISE_TH) and sets when sample_code < 344 (UV_FALL_TH). Codes from 344 to 364, both included, leave it unchanged.
- R3: The overvoltage flag uses hysteresis and updates one clock after the code. It sets when sample_code > 788 (OV_RISE_TH) and clears when sample_code < 772 (OV_FALL_TH). Codes from 772 to 788, both included, leave it unchanged.
- R4: From the unqualified state, gate_en rises only after the window has been held for DELAY_TICKS timebase ticks without a break. One tick occurs every PRESCALE clocks, with defaults of 8 ticks and 4 clocks. The gate is low 26 clocks after an in-window code is applied and high 40 clocks after it.
- R5: If the code leaves the window during the power-on delay, the delay starts again from zero.
- R6: With the gate on, an excursion out of the window that covers fewer than DELAY_TICKS ticks is ignored. This includes an excursion exactly one tick short, (DELAY_TICKS-1)*PRESCALE clocks of bad code. gate_en stays 1 and v_fault stays 0.
- R7: An excursion that covers DELAY_TICKS ticks or more drops gate_en to 0 and raises v_fault.
- R8: After a voltage fault, an in-window code raises gate_en again two clocks later, with no power-on delay, and v_fault clears.
- R9: supply_lockout=1 forces gate_en to 0 in the same cycle. After lockout is released, the full power-on delay of R4 applies again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_code | input | CODE_W (10) | Divided supply sample code |
| supply_lockout | input | 1 | Supply lockout, forces gate off |
| gate_en | output | 1 | Gate drive enable request |
| uv_flag | output | 1 | Undervoltage hysteresis state |
| ov_flag | output | 1 | Overvoltage hysteresis state |
| v_fault | output | 1 | Filtered voltage fault is latched while out of window |

## Verification
The assertions assume that sample_code holds a known value at every clock edge outside reset. They also assume that supply_lockout is driven to a known level, because both input-referenced properties look one cycle into the past.

The stimulus keeps to these assumptions. Both inputs are changed only on the falling clock edge and are held steady through reset. The random phase draws codes clustered around the four thresholds, with occasional codes from the full range, so that every crossing and every equal-to-threshold case is reached. The directed phase holds each excursion for a whole number of clocks that is chosen against the tick period.

// File: rtl/svq_pkg.sv
package svq_pkg;

    localparam int CODE_W_DEF      = 10;
    localparam int UV_FALL_DEF     = 344;
    localparam int UV_RISE_DEF     = 364;
    localparam int OV_FALL_DEF     = 772;
    localparam int OV_RISE_DEF     = 788;
    localparam int PRESCALE_DEF    = 4;
    localparam int DELAY_TICKS_DEF = 8;

    typedef enum logic [2:0] {
        SQ_UNQ   = 3'd0,
        SQ_POR   = 3'd1,
        SQ_ON    = 3'd2,
        SQ_FILT  = 3'd3,
        SQ_FAULT = 3'd4
    } sq_state_e;

    typedef struct packed {
        logic uv;
        logic ov;
    } win_flags_t;

    function automatic logic in_window(win_flags_t f);
        return !f.uv && !f.ov;
    endfunction

    function automatic logic drives_gate(sq_state_e s);
        return (s == SQ_ON) || (s == SQ_FILT);
    endfunction

    function automatic logic is_timed(sq_state_e s);
        return (s == SQ_POR) || (s == SQ_FILT);
    endfunction

endpackage

// File: rtl/svq_tick_gen.sv
module svq_tick_gen #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (PRESCALE <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] div_q;

            always_ff @(posedge clk) begin
                if (rst)               div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                   div_q <= div_q + 1'b1;
            end

            assign tick = (div_q == LAST);

            // R4: ticks are isolated pulses, one per prescale period
            assert_tick_single_R4: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/svq_hyst.sv
module svq_hyst #(
    parameter int CODE_W    = 10,
    parameter int SET_TH    = 344,
    parameter int CLR_TH    = 364,
    parameter bit HIGH_SIDE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    output logic              flag
);
    localparam logic [CODE_W-1:0] SET_C = CODE_W'(SET_TH);
    localparam logic [CODE_W-1:0] CLR_C = CODE_W'(CLR_TH);
    localparam logic              RST_V = !HIGH_SIDE;

    logic set_c;
    logic clr_c;

    generate
        if (HIGH_SIDE) begin : g_high
            assign set_c = code > SET_C;
            assign clr_c = code < CLR_C;
        end else begin : g_low
            assign set_c = code < SET_C;
            assign clr_c = code > CLR_C;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                 flag <= RST_V;
        else if (!flag && set_c) flag <= 1'b1;
        else if (flag && clr_c)  flag <= 1'b0;
    end
endmodule

// File: rtl/svq_delay_cnt.sv
module svq_delay_cnt #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign done = tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) cnt_q <= '0;
        else if (done)    cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_q + 1'b1;
    end

    // R4: the tick count never passes the programmed delay
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
endmodule

// File: rtl/supply_window_seq.sv
module supply_window_seq
    import svq_pkg::*;
#(
    parameter int CODE_W      = CODE_W_DEF,
    parameter int UV_FALL_TH  = UV_FALL_DEF,
    parameter int UV_RISE_TH  = UV_RISE_DEF,
    parameter int OV_FALL_TH  = OV_FALL_DEF,
    parameter int OV_RISE_TH  = OV_RISE_DEF,
    parameter int PRESCALE    = PRESCALE_DEF,
    parameter int DELAY_TICKS = DELAY_TICKS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] sample_code,
    input  logic              supply_lockout,
    output logic              gate_en,
    output logic              uv_flag,
    output logic              ov_flag,
    output logic              v_fault
);
    localparam logic [CODE_W-1:0] UVF_C = CODE_W'(UV_FALL_TH);
    localparam logic [CODE_W-1:0] UVR_C = CODE_W'(UV_RISE_TH);
    localparam logic [CODE_W-1:0] OVF_C = CODE_W'(OV_FALL_TH);
    localparam logic [CODE_W-1:0] OVR_C = CODE_W'(OV_RISE_TH);

    win_flags_t flags;
    sq_state_e  state_q, state_d;
    logic       tick, t_done, t_clear, inwin;

    svq_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    svq_hyst #(.CODE_W(CODE_W), .SET_TH(UV_FALL_TH), .CLR_TH(UV_RISE_TH),
               .HIGH_SIDE(1'b0)) u_uv (
        .clk(clk), .rst(rst), .code(sample_code), .flag(flags.uv)
    );

    svq_hyst #(.CODE_W(CODE_W), .SET_TH(OV_RISE_TH), .CLR_TH(OV_FALL_TH),
               .HIGH_SIDE(1'b1)) u_ov (
        .clk(clk), .rst(rst), .code(sample_code), .flag(flags.ov)
    );

    svq_delay_cnt #(.LIMIT(DELAY_TICKS)) u_delay (
        .clk(clk), .rst(rst), .clear(t_clear), .tick(tick), .done(t_done)
    );

    assign inwin = in_window(flags);

    always_comb begin
        state_d = state_q;
        if (supply_lockout) begin
            state_d = SQ_UNQ;
        end else begin
            unique case (state_q)
                SQ_UNQ:   if (inwin) state_d = SQ_POR;
                SQ_POR:   if (!inwin) state_d = SQ_UNQ;
                          else if (t_done) state_d = SQ_ON;
                SQ_ON:    if (!inwin) state_d = SQ_FILT;
                SQ_FILT:  if (inwin) state_d = SQ_ON;
                          else if (t_done) state_d = SQ_FAULT;
                SQ_FAULT: if (inwin) state_d = SQ_ON;
                default:  state_d = SQ_UNQ;
            endcase
        end
    end

    // one counter serves both timed states; it restarts on every state change
    assign t_clear = !is_timed(state_q) || (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_UNQ;
        else     state_q <= state_d;
    end

    assign gate_en = drives_gate(state_q) && !supply_lockout;
    assign uv_flag = flags.uv;
    assign ov_flag = flags.ov;
    assign v_fault = (state_q == SQ_FAULT);

    assert_uv_set_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(uv_flag) |-> ($past(sample_code) < UVF_C));
    assert_uv_clr_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(uv_flag) |-> ($past(sample_code) > UVR_C));
    assert_ov_set_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ov_flag) |-> ($past(sample_code) > OVR_C));
    assert_ov_clr_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(ov_flag) |-> ($past(sample_code) < OVF_C));
    assert_gate_window_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_en) |-> $past(!uv_flag && !ov_flag));
    assert_fault_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(v_fault) |-> $past(uv_flag || ov_flag));
    assert_lockout_hold_R9: assert property (@(posedge clk) disable iff (rst)
        supply_lockout |=> !gate_en);
endmodule

// File: tb/tb_supply_window_seq.sv
module tb_supply_window_seq;
    localparam int UVF = 344, UVR = 364, OVF = 772, OVR = 788;
    localparam int MID = 560, LOWV = 100, HIGHV = 900;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] sample_code = '0;
    logic       supply_lockout = 1'b0;
    logic       gate_en, uv_flag, ov_flag, v_fault;

    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    supply_window_seq dut (
        .clk(clk), .rst(rst), .sample_code(sample_code),
        .supply_lockout(supply_lockout), .gate_en(gate_en),
        .uv_flag(uv_flag), .ov_flag(ov_flag), .v_fault(v_fault)
    );

    function automatic logic nx_uv(logic cur, int code);
        if (!cur && code < UVF) return 1'b1;
        if (cur && code > UVR)  return 1'b0;
        return cur;
    endfunction

    function automatic logic nx_ov(logic cur, int code);
        if (!cur && code > OVR) return 1'b1;
        if (cur && code < OVF)  return 1'b0;
        return cur;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sample_code = '0;
        supply_lockout = 1'b0;
        step(3);
        rst = 1'b0;
    endtask

    task automatic bring_up();
        do_reset();
        sample_code = 10'(MID);
        step(40);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        logic m_uv, m_ov;
        void'($urandom(32'd4217));

        // R1: reset state
        step(3);
        chk("R1 gate", int'(gate_en), 0);
        chk("R1 uv", int'(uv_flag), 1);
        chk("R1 ov", int'(ov_flag), 0);
        chk("R1 fault", int'(v_fault), 0);
        rst = 1'b0;
        step(1);
        chk("R1 gate after release", int'(gate_en), 0);

        // R2/R3: random codes near thresholds against a hysteresis model
        m_uv = 1'b1;
        m_ov = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            int c;
            int sel;
            chk("R2 uv model", int'(uv_flag), int'(m_uv));
            chk("R3 ov model", int'(ov_flag), int'(m_ov));
            sel = int'($urandom_range(0, 4));
            case (sel)
                0: c = UVF + int'($urandom_range(0, 8)) - 4;
                1: c = UVR + int'($urandom_range(0, 8)) - 4;
                2: c = OVF + int'($urandom_range(0, 8)) - 4;
                3: c = OVR + int'($urandom_range(0, 8)) - 4;
                default: c = int'($urandom_range(0, 1023));
            endcase
            sample_code = 10'(c);
            m_uv = nx_uv(m_uv, c);
            m_ov = nx_ov(m_ov, c);
            step(1);
        end

        // R2 boundaries: equality does not switch
        do_reset();
        sample_code = 10'(UVR);
        step(5);
        chk("R2 uv holds at rise th", int'(uv_flag), 1);
        sample_code = 10'(UVR + 1);
        step(1);
        chk("R2 uv clears above rise th", int'(uv_flag), 0);
        sample_code = 10'(UVF);
        step(5);
        chk("R2 uv holds at fall th", int'(uv_flag), 0);
        sample_code = 10'(UVF - 1);
        step(1);
        chk("R2 uv sets below fall th", int'(uv_flag), 1);

        // R4: power-on delay
        do_reset();
        sample_code = 10'(MID);
        step(26);
        chk("R4 gate low during delay", int'(gate_en), 0);
        step(14);
        chk("R4 gate high after delay", int'(gate_en), 1);

        // R5: interrupted delay restarts
        do_reset();
        sample_code = 10'(MID);
        step(20);
        sample_code = 10'(LOWV);
        step(2);
        sample_code = 10'(MID);
        step(26);
        chk("R5 delay restarted", int'(gate_en), 0);
        step(14);
        chk("R5 gate after full delay", int'(gate_en), 1);

        // R6: undervoltage excursion one tick short
        sample_code = 10'(LOWV);
        step(10);
        chk("R6 gate held during filter", int'(gate_en), 1);
        step(18);
        sample_code = 10'(MID);
        step(3);
        chk("R6 uv short pulse gate", int'(gate_en), 1);
        chk("R6 uv short pulse fault", int'(v_fault), 0);

        // R6: overvoltage excursion one tick short
        sample_code = 10'(HIGHV);
        step(28);
        sample_code = 10'(MID);
        step(3);
        chk("R6 ov short pulse gate", int'(gate_en), 1);
        chk("R6 ov short pulse fault", int'(v_fault), 0);

        // R7: long undervoltage excursion, then R8 recovery
        sample_code = 10'(LOWV);
        step(40);
        chk("R7 uv fault gate", int'(gate_en), 0);
        chk("R7 uv fault flag", int'(v_fault), 1);
        sample_code = 10'(MID);
        step(2);
        chk("R8 uv recovery gate", int'(gate_en), 1);
        chk("R8 uv recovery fault", int'(v_fault), 0);

        // R7 overvoltage, R3 hysteresis band, R8 recovery
        sample_code = 10'(HIGHV);
        step(40);
        chk("R7 ov fault gate", int'(gate_en), 0);
        sample_code = 10'(780);
        step(10);
        chk("R3 ov holds in band", int'(ov_flag), 1);
        chk("R3 gate stays off in band", int'(gate_en), 0);
        sample_code = 10'(700);
        step(2);
        chk("R8 ov recovery gate", int'(gate_en), 1);

        // R9: lockout
        bring_up();
        chk("R9 gate before lockout", int'(gate_en), 1);
        supply_lockout = 1'b1;
        #1;
        chk("R9 gate off same cycle", int'(gate_en), 0);
        step(3);
        supply_lockout = 1'b0;
        step(20);
        chk("R9 delay reapplied", int'(gate_en), 0);
        step(20);
        chk("R9 gate after delay", int'(gate_en), 1);

        report();
        $finish;
    end
endmodule